// File: doc/BRIEF.md
# Peripheral Bus Bridge with Two Frames

This bridge sits between a processor's separate memory paths and one narrow peripheral bus. It has three incoming requesters: a data-write path, a data-read path and a program-read path. Each holds its request until the bridge pulses the matching done signal. The bridge takes one request at a time, places it on a 16-bit-address peripheral bus with a 32-bit data path, and returns read data on a 32-bit result bus.

Bit 16 of the incoming address selects one of two peripheral frames. The wide frame takes 16-bit and 32-bit accesses directly. The narrow frame takes only 16-bit accesses, so a 32-bit request to it becomes two half-word transfers. Every peripheral transfer has a strobe cycle and then a data cycle. While a request is in service, the other requesters wait.

Top module: `periph_bridge`

## Requirements
- R1: While reset is held, `p_stb`, `p_fsel` and all three done outputs are zero.
- R2: A request accepted at a clock edge raises `p_stb` for the one cycle that follows. The next cycle is the data cycle, with `p_stb` low and address, frame select and write data unchanged. The done pulse is high for the single cycle after the last data cycle.
- R3: Address bit 16 selects the frame: 0 gives `p_fsel`=2'b01 (wide frame) and 1 gives `p_fsel`=2'b10 (narrow frame). The low 16 address bits appear on `p_addr`. `p_fsel` is 2'b00 when no transfer is running.
- R4: A 32-bit access (`*_w32`=1) to the wide frame is one transfer with `p_w32`=1. All 32 bits of write data go out and all 32 bits of read data come back.
- R5: A 32-bit access to the narrow frame is two transfers. The first is at the given address and carries bits 15:0. The second is at that address plus one (modulo 2^16) and carries bits 31:16. Done follows only the second transfer.
- R6: A 16-bit read returns `p_rdata[15:0]` on `rdata[15:0]`, with `rdata[31:16]` zero. A 16-bit write, and each half of a split write, drives its half-word on `p_wdata[15:0]` with `p_wdata[31:16]` zero.
- R7: When several requests are pending, the write is served first, then the data read, then the program read. A new request is never granted in a cycle where a done pulse is high.
- R8: A program-read request uses a 22-bit address. Its frame and peripheral address are decoded the same way as the data paths.
- R9: At most one done output is high at a time. It belongs to the requester that was served, and `rdata` is valid in the same cycle for reads.
- R10: `p_w32` is never high while the narrow frame is selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_req | input | 1 | Data-write request, held until wr_done |
| wr_addr | input | 32 | Data-write address |
| wr_data | input | 32 | Data-write value |
| wr_w32 | input | 1 | Data write is 32 bits wide |
| wr_done | output | 1 | Data write finished |
| rd_req | input | 1 | Data-read request, held until rd_done |
| rd_addr | input | 32 | Data-read address |
| rd_w32 | input | 1 | Data read is 32 bits wide |
| rd_done | output | 1 | Data read finished, rdata valid |
| pf_req | input | 1 | Program-read request, held until pf_done |
| pf_addr | input | 22 | Program-read address |
| pf_w32 | input | 1 | Program read is 32 bits wide |
| pf_done | output | 1 | Program read finished, rdata valid |
| rdata | output | 32 | Read result |
| p_addr | output | 16 | Peripheral address |
| p_fsel | output | 2 | Frame select: bit 0 wide frame, bit 1 narrow frame |
| p_stb | output | 1 | Strobe, high in the first cycle of a transfer |
| p_we | output | 1 | Transfer is a write |
| p_w32 | output | 1 | Transfer is 32 bits wide |
| p_wdata | output | 32 | Peripheral write data |
| p_rdata | input | 32 | Peripheral read data, sampled at the end of the data cycle |

## Verification
The hardest case to reach is all three requesters asserting in the same cycle while one of them targets the narrow frame. That is the only case that tests the priority order, the one-cycle grant block after each done, and a split transfer queued behind other traffic. The bench raises all three requests at the same clock edge. Its reference model predicts the full sequence of strobe, data, done and idle cycles, and the bench drops each request only when that requester's done appears. Another sequence sends a 32-bit narrow-frame write at address 0xFFFF, so the second half-word wraps to address 0.

// File: rtl/periph_bridge.sv
module periph_bridge #(
  parameter int AW       = 32,
  parameter int PRW      = 22,
  parameter int PAW      = 16,
  parameter int DW       = 32,
  parameter int FSEL_BIT = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_req,
  input  logic [AW-1:0]  wr_addr,
  input  logic [DW-1:0]  wr_data,
  input  logic           wr_w32,
  output logic           wr_done,
  input  logic           rd_req,
  input  logic [AW-1:0]  rd_addr,
  input  logic           rd_w32,
  output logic           rd_done,
  input  logic           pf_req,
  input  logic [PRW-1:0] pf_addr,
  input  logic           pf_w32,
  output logic           pf_done,
  output logic [DW-1:0]  rdata,
  output logic [PAW-1:0] p_addr,
  output logic [1:0]     p_fsel,
  output logic           p_stb,
  output logic           p_we,
  output logic           p_w32,
  output logic [DW-1:0]  p_wdata,
  input  logic [DW-1:0]  p_rdata
);
  localparam int HW = DW / 2;

  typedef enum logic [1:0] {S_IDLE, S_ADDR, S_DATA} st_t;

  st_t           st;
  logic [2:0]    src_oh, done_r;
  logic [PAW-1:0] a_lat;
  logic          narrow, w32, beat;
  logic [DW-1:0] wd_lat, rd_q;
  logic [HW-1:0] lo_q;

  logic          busy, split, grant;
  logic [2:0]    g_oh;
  logic [AW-1:0] g_addr;
  logic          g_w32;

  assign busy  = (st != S_IDLE);
  assign split = narrow && w32;
  assign grant = (st == S_IDLE) && (done_r == 3'b000) && (wr_req || rd_req || pf_req);

  assign g_oh   = wr_req ? 3'b001 : (rd_req ? 3'b010 : 3'b100);
  assign g_addr = wr_req ? wr_addr : (rd_req ? rd_addr : {{(AW-PRW){1'b0}}, pf_addr});
  assign g_w32  = wr_req ? wr_w32 : (rd_req ? rd_w32 : pf_w32);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      src_oh <= 3'b000;
      done_r <= 3'b000;
      a_lat  <= '0;
      narrow <= 1'b0;
      w32    <= 1'b0;
      beat   <= 1'b0;
      wd_lat <= '0;
      rd_q   <= '0;
      lo_q   <= '0;
    end else begin
      done_r <= 3'b000;
      case (st)
        S_IDLE: if (grant) begin
          st     <= S_ADDR;
          src_oh <= g_oh;
          a_lat  <= g_addr[PAW-1:0];
          narrow <= g_addr[FSEL_BIT];
          w32    <= g_w32;
          wd_lat <= wr_data;
          beat   <= 1'b0;
        end
        S_ADDR: st <= S_DATA;
        S_DATA: begin
          if (!src_oh[0]) begin
            if (split && !beat)  lo_q <= p_rdata[HW-1:0];
            else if (split)      rd_q <= {p_rdata[HW-1:0], lo_q};
            else if (w32)        rd_q <= p_rdata;
            else                 rd_q <= {{HW{1'b0}}, p_rdata[HW-1:0]};
          end
          if (split && !beat) begin
            beat <= 1'b1;
            st   <= S_ADDR;
          end else begin
            st     <= S_IDLE;
            done_r <= src_oh;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign p_stb   = (st == S_ADDR);
  assign p_fsel  = busy ? (narrow ? 2'b10 : 2'b01) : 2'b00;
  assign p_we    = busy && src_oh[0];
  assign p_w32   = busy && w32 && !narrow;
  assign p_addr  = a_lat + {{(PAW-1){1'b0}}, beat};
  assign p_wdata = !p_we           ? '0 :
                   split           ? {{HW{1'b0}}, (beat ? wd_lat[DW-1:HW] : wd_lat[HW-1:0])} :
                   w32             ? wd_lat :
                                     {{HW{1'b0}}, wd_lat[HW-1:0]};

  assign wr_done = done_r[0];
  assign rd_done = done_r[1];
  assign pf_done = done_r[2];
  assign rdata   = rd_q;

  p_reset_quiet_r1: assert property (@(posedge clk) !rst_n |=> (!p_stb && p_fsel == 2'b00 && done_r == 3'b000));
  p_stb_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    p_stb |=> (!p_stb && $stable(p_addr) && $stable(p_fsel) && $stable(p_wdata)));
  p_done_after_data_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_done || rd_done || pf_done) |-> ($past(p_fsel != 2'b00 && !p_stb) && p_fsel == 2'b00));
  p_fsel_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(p_fsel));
  p_write_first_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE && done_r == 3'b000 && wr_req) |=> (p_stb && p_we));
  p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wr_done, rd_done, pf_done}));
  p_narrow_no32_r10: assert property (@(posedge clk) disable iff (!rst_n) p_fsel[1] |-> !p_w32);
endmodule

// File: tb/sim_periph_bridge.sv
module sim_periph_bridge;
  localparam int CLK_P = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  logic        wr_req = 0, rd_req = 0, pf_req = 0;
  logic [31:0] wr_addr = 0, wr_data = 0, rd_addr = 0;
  logic [21:0] pf_addr = 0;
  logic        wr_w32 = 0, rd_w32 = 0, pf_w32 = 0;
  logic        wr_done, rd_done, pf_done;
  logic [31:0] rdata, p_wdata, p_rdata;
  logic [15:0] p_addr;
  logic [1:0]  p_fsel;
  logic        p_stb, p_we, p_w32;

  periph_bridge u0 (
    .clk(clk), .rst_n(rst_n),
    .wr_req(wr_req), .wr_addr(wr_addr), .wr_data(wr_data), .wr_w32(wr_w32), .wr_done(wr_done),
    .rd_req(rd_req), .rd_addr(rd_addr), .rd_w32(rd_w32), .rd_done(rd_done),
    .pf_req(pf_req), .pf_addr(pf_addr), .pf_w32(pf_w32), .pf_done(pf_done),
    .rdata(rdata), .p_addr(p_addr), .p_fsel(p_fsel), .p_stb(p_stb), .p_we(p_we),
    .p_w32(p_w32), .p_wdata(p_wdata), .p_rdata(p_rdata)
  );

  logic [31:0] wmem [64];
  logic [15:0] nmem [64];
  logic [31:0] sw [64];
  logic [15:0] sn [64];

  initial begin
    for (int i = 0; i < 64; i++) begin
      wmem[i] = (i * 32'h0101_0101) ^ 32'hC3C3_0000;
      nmem[i] = 16'(i * 16'h0111 + 16'h0F00);
      sw[i] = wmem[i];
      sn[i] = nmem[i];
    end
  end

  always @(posedge clk) begin
    if (p_stb && p_we && p_fsel == 2'b01) begin
      if (p_w32) wmem[p_addr[5:0]] <= p_wdata;
      else       wmem[p_addr[5:0]][15:0] <= p_wdata[15:0];
    end
    if (p_stb && p_we && p_fsel == 2'b10) nmem[p_addr[5:0]] <= p_wdata[15:0];
  end

  assign p_rdata = (p_fsel == 2'b01) ? wmem[p_addr[5:0]] :
                   (p_fsel == 2'b10) ? {16'hA5A5, nmem[p_addr[5:0]]} : 32'h0;

  typedef struct {
    logic        stb, we, w32;
    logic [1:0]  fsel;
    logic [15:0] addr;
    logic [31:0] wdata;
    logic [2:0]  done;
    logic [31:0] rd;
    string       tag;
  } rec_t;

  rec_t q[$];
  int n_chk = 0, n_fail = 0;

  task automatic plan(input int src, input logic [31:0] a, input logic w32,
                      input logic [31:0] d, input string tag, input bit gap);
    rec_t r;
    logic nar = a[16];
    int nb = (nar && w32) ? 2 : 1;
    logic [5:0] i0 = a[5:0];
    logic [5:0] i1 = 6'(a[15:0] + 16'd1);
    for (int b = 0; b < nb; b++) begin
      r.stb = 1; r.we = (src == 0); r.w32 = w32 && !nar; r.fsel = nar ? 2'b10 : 2'b01;
      r.addr = a[15:0] + 16'(b); r.done = 0; r.rd = 0; r.tag = tag;
      if (src != 0)      r.wdata = 0;
      else if (nar)      r.wdata = {16'h0, (b == 1) ? d[31:16] : d[15:0]};
      else if (w32)      r.wdata = d;
      else               r.wdata = {16'h0, d[15:0]};
      q.push_back(r);
      r.stb = 0;
      q.push_back(r);
    end
    r.stb = 0; r.we = 0; r.w32 = 0; r.fsel = 0; r.addr = 0; r.wdata = 0;
    r.done = 3'(1 << src); r.rd = 0;
    if (src == 0) begin
      if (!nar && w32) sw[i0] = d;
      else if (!nar)   sw[i0][15:0] = d[15:0];
      else if (w32)    begin sn[i0] = d[15:0]; sn[i1] = d[31:16]; end
      else             sn[i0] = d[15:0];
    end else begin
      if (!nar && w32) r.rd = sw[i0];
      else if (!nar)   r.rd = {16'h0, sw[i0][15:0]};
      else if (w32)    r.rd = {sn[i1], sn[i0]};
      else             r.rd = {16'h0, sn[i0]};
    end
    q.push_back(r);
    if (gap) begin
      r.done = 0; r.rd = 0;
      q.push_back(r);
    end
  endtask

  task automatic fail_line(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_fail++;
    $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
  endtask

  always @(posedge clk) begin
    #(CLK_P/4);
    if (rst_n) begin
      rec_t e;
      int bad;
      if (q.size() > 0) e = q.pop_front();
      else begin
        e.stb = 0; e.we = 0; e.w32 = 0; e.fsel = 0; e.addr = 0; e.wdata = 0;
        e.done = 0; e.rd = 0; e.tag = "R2 idle";
      end
      n_chk++;
      bad = n_fail;
      if (p_stb !== e.stb) fail_line(e.tag, "p_stb", 32'(p_stb), 32'(e.stb));
      if (p_fsel !== e.fsel) fail_line(e.tag, "p_fsel", 32'(p_fsel), 32'(e.fsel));
      if (p_fsel != 2'b00) begin
        if (p_we !== e.we) fail_line(e.tag, "p_we", 32'(p_we), 32'(e.we));
        if (p_w32 !== e.w32) fail_line(e.tag, "p_w32", 32'(p_w32), 32'(e.w32));
        if (p_addr !== e.addr) fail_line(e.tag, "p_addr", 32'(p_addr), 32'(e.addr));
        if (p_wdata !== e.wdata) fail_line(e.tag, "p_wdata", p_wdata, e.wdata);
      end
      if ({pf_done, rd_done, wr_done} !== e.done)
        fail_line(e.tag, "done", 32'({pf_done, rd_done, wr_done}), 32'(e.done));
      if ((e.done[1] || e.done[2]) && rdata !== e.rd) fail_line(e.tag, "rdata", rdata, e.rd);
      if (n_fail > bad) n_fail = bad + 1;
    end
  end

  task automatic wait_idle();
    forever begin
      @(posedge clk);
      #(CLK_P/4);
      if (wr_done) wr_req = 0;
      if (rd_done) rd_req = 0;
      if (pf_done) pf_req = 0;
      if (q.size() == 0 && !wr_req && !rd_req && !pf_req) break;
    end
    repeat (2) @(negedge clk);
  endtask

  task automatic do_wr(input logic [31:0] a, input logic [31:0] d, input logic w, input string tag);
    @(negedge clk);
    wr_addr = a; wr_data = d; wr_w32 = w; wr_req = 1;
    plan(0, a, w, d, tag, 0);
    wait_idle();
  endtask

  task automatic do_rd(input logic [31:0] a, input logic w, input string tag);
    @(negedge clk);
    rd_addr = a; rd_w32 = w; rd_req = 1;
    plan(1, a, w, 0, tag, 0);
    wait_idle();
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual hung expected finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    n_chk++;
    if (p_stb !== 1'b0 || p_fsel !== 2'b00 || {wr_done, rd_done, pf_done} !== 3'b000) begin
      n_fail++;
      $display("FAIL R1 reset outputs: actual %b%b%b expected 0000", p_stb, p_fsel, {wr_done, rd_done, pf_done});
    end
    rst_n = 1;
    repeat (2) @(negedge clk);

    do_wr(32'h0000_0005, 32'h1234_BEEF, 0, "R2 wide 16-bit write");
    do_rd(32'h0000_0005, 0, "R3 wide 16-bit read");
    do_wr(32'h0000_0008, 32'hCAFE_F00D, 1, "R4 wide 32-bit write");
    do_rd(32'h0000_0008, 1, "R4 wide 32-bit read");
    do_wr(32'h0001_000C, 32'h89AB_4567, 1, "R5/R10 narrow split write");
    do_rd(32'h0001_000C, 1, "R5 narrow split read");
    do_rd(32'h0001_000D, 0, "R6 narrow 16-bit read zero-extended");
    do_rd(32'h0000_0011, 0, "R6 wide 16-bit read zero-extended");
    do_wr(32'h0001_FFFF, 32'h0BAD_F1E5, 1, "R5 split write address wrap");
    do_rd(32'h0001_0000, 0, "R5 wrapped high half read");

    @(negedge clk);
    wr_addr = 32'h0001_0020; wr_data = 32'h0000_7777; wr_w32 = 1; wr_req = 1;
    rd_addr = 32'h0000_0003; rd_w32 = 1; rd_req = 1;
    pf_addr = 22'h01_0020; pf_w32 = 0; pf_req = 1;
    plan(0, 32'h0001_0020, 1, 32'h0000_7777, "R7 write first", 1);
    plan(1, 32'h0000_0003, 1, 0, "R7 data read second", 1);
    plan(2, 32'h0001_0020, 0, 0, "R9 program read last", 0);
    wait_idle();

    @(negedge clk);
    pf_addr = 22'h2A_0004; pf_w32 = 1; pf_req = 1;
    plan(2, 32'h002A_0004, 1, 0, "R8 program read wide frame", 0);
    wait_idle();

    @(negedge clk);
    rd_addr = 32'h0001_0021; rd_w32 = 0; rd_req = 1;
    pf_addr = 22'h01_000C; pf_w32 = 1; pf_req = 1;
    plan(1, 32'h0001_0021, 0, 0, "R7 read over program", 1);
    plan(2, 32'h0001_000C, 1, 0, "R8 program split read", 0);
    wait_idle();

    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule